// File: doc/BRIEF.md
# Per-Thread Interrupt Presenter Register Window

Each processor thread has one of these blocks. It holds the thread's interrupt priority state and exposes it through a 4 KB memory-mapped window. The state is:

- the current processor priority;
- one pending interrupt, made up of a source number and its priority;
- an inter-processor request priority;
- three general-purpose link words.

Each access carries an address and a byte count. The decoder turns that pair into one of these operations: poll, accept, end-of-interrupt, priority update, inter-processor request update, or link access. The same offset can mean different things at different widths. For example, a one-byte access at the word base reaches only the priority byte, while a full-word access at the same address accepts the pending interrupt (on a read) or ends it (on a write).

On the other side is a small source-controller port. A source offers an interrupt number and a priority. The presenter either keeps it as the pending interrupt or rejects it at once. When a more favoured interrupt displaces the pending one, the displaced source is rejected. An end-of-interrupt sends a pulse back to the source controller. The interrupt line to the processor is high while an interrupt is pending that is more favoured than the current priority. Numerically lower priority values are more favoured, and 0xFF is the least favoured.

Top module: `icp_presenter`

## Requirements
- R1: After reset, the current priority is 0x00, the inter-processor request priority is 0xFF, nothing is pending, all link words are zero, and irq, err, rsp_valid, rej_valid and eoi_valid are low.
- R2: Every read gets rsp_valid with rsp_rdata one cycle after the request; writes get no response. At offset 0, a 4-byte read returns {priority[31:24], source[23:0]} and changes nothing. A 1-byte read at address 0 returns the current priority in rdata[7:0], with the upper bits zero.
- R3: At offset 4, a 4-byte read returns the same word as the poll and then accepts: the current priority takes the pending priority, the pending slot clears, and irq drops. With nothing pending, it returns source 0 and changes nothing. A 1-byte read at offset 4 acts as a priority-byte poll and does not accept.
- R4: At offset 4, a 1-byte write sets the current priority to wdata[7:0]. If the new value is numerically less than or equal to the pending priority, the pending source is rejected (unless it is source 2) and cleared.
- R5: At offset 4, a 4-byte write is an end-of-interrupt. The current priority becomes wdata[31:24]. If wdata[23:0] is not 2, an eoi_valid pulse carries that number. The R4 drop rule then applies.
- R6: Offset 12 accepts only 1-byte accesses at address 12. A read returns the request priority in rdata[7:0]. A write stores wdata[7:0]. If the new value is below both the current priority and the pending priority, source 2 becomes pending at that priority, and any displaced source other than 2 is rejected.
- R7: Offsets 16, 20 and 24 are 32-bit link words that take only 4-byte reads and writes, and have no other effect.
- R8: These accesses are illegal: any other offset in the window, any other width at a mapped offset (a 1-byte access counts only at an address with bits [1:0] zero), and any write to offset 0. An illegal read returns 0xFFFFFFFF. An illegal write changes nothing. Every illegal access sets err, which stays set until reset.
- R9: src_ready is high only in cycles with no register request. A source offered with src_ready high is kept if its priority is below both the current and the pending priority, and any displaced source other than 2 is rejected. Otherwise the offered source itself is rejected, via rej_valid/rej_src one cycle later. Sources offer numbers other than 0 and 2.
- R10: irq is high exactly when an interrupt is pending, and the pending priority is then always below the current priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address inside the window |
| req_bytes | input | 3 | Access size in bytes (1 to 4 legal encodings) |
| req_wdata | input | 32 | Write data, right-aligned for byte accesses |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| src_valid | input | 1 | Source controller offers an interrupt |
| src_id | input | 24 | Offered source number |
| src_prio | input | 8 | Offered priority |
| src_ready | output | 1 | Offer is taken this cycle |
| rej_valid | output | 1 | Reject pulse to source controller |
| rej_src | output | 24 | Rejected source number |
| eoi_valid | output | 1 | End-of-interrupt pulse |
| eoi_src | output | 24 | Source number being ended |
| irq | output | 1 | Interrupt request to the thread |
| err | output | 1 | Sticky illegal-access flag |

## Verification
The hardest case to reach is a pending inter-processor request that an external source then displaces, followed by a new request-priority write that takes the slot back. The first step must produce no reject, and the second must reject the external source. The stimulus gets there by first opening the current priority, then writing the request priority, offering a more favoured source, and then writing an even more favoured request priority. Every illegal width and offset is run only after the legal sequences, so that the sticky error flag can be seen low first and then set by the first illegal access.

// File: rtl/icp_pkg.sv
package icp_pkg;

   // Word offsets inside the window (byte offset / 4)
   localparam int WOFF_POLL = 0;
   localparam int WOFF_XIRR = 1;
   localparam int WOFF_MFRR = 3;

   typedef enum logic [3:0] {
      OP_NONE,
      OP_POLL_WORD,
      OP_POLL_BYTE,
      OP_ACCEPT,
      OP_CPPR_WR,
      OP_EOI,
      OP_MFRR_RD,
      OP_MFRR_WR,
      OP_LINK_RD,
      OP_LINK_WR,
      OP_BAD_RD,
      OP_BAD_WR
   } icp_op_e;

endpackage

// File: rtl/icp_decode.sv
module icp_decode
   import icp_pkg::*;
#(
   parameter int ADDR_W    = 12,
   parameter int NUM_LINKS = 3,
   parameter int LINK_BASE = 16,
   parameter int IDX_W     = 2
) (
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [2:0]        req_bytes,
   output icp_op_e           op,
   output logic [IDX_W-1:0]  link_idx
);
   localparam int OFF_W   = ADDR_W - 2;
   localparam int LINK_W0 = LINK_BASE / 4;

   logic [OFF_W-1:0] woff;
   logic             is_b0;
   logic             is_w;
   int               rel;

   always_comb begin
      woff     = req_addr[ADDR_W-1:2];
      is_b0    = (req_bytes == 3'd1) && (req_addr[1:0] == 2'b00);
      is_w     = (req_bytes == 3'd4);
      rel      = int'(woff) - LINK_W0;
      link_idx = rel[IDX_W-1:0];
      op       = OP_NONE;
      if (req_valid) begin
         op = req_write ? OP_BAD_WR : OP_BAD_RD;
         if (woff == OFF_W'(WOFF_POLL)) begin
            if (!req_write) begin
               if (is_w)       op = OP_POLL_WORD;
               else if (is_b0) op = OP_POLL_BYTE;
            end
         end else if (woff == OFF_W'(WOFF_XIRR)) begin
            if (req_write) begin
               if (is_w)       op = OP_EOI;
               else if (is_b0) op = OP_CPPR_WR;
            end else begin
               if (is_w)       op = OP_ACCEPT;
               else if (is_b0) op = OP_POLL_BYTE;
            end
         end else if (woff == OFF_W'(WOFF_MFRR)) begin
            if (is_b0) op = req_write ? OP_MFRR_WR : OP_MFRR_RD;
         end else if (rel >= 0 && rel < NUM_LINKS) begin
            if (is_w) op = req_write ? OP_LINK_WR : OP_LINK_RD;
         end
      end
   end
endmodule

// File: rtl/icp_links.sv
module icp_links #(
   parameter int NUM_LINKS = 3,
   parameter int DATA_W    = 32,
   parameter int IDX_W     = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  idx,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] word_q [NUM_LINKS];

   for (genvar i = 0; i < NUM_LINKS; i++) begin : g_link
      always_ff @(posedge clk) begin
         if (!rst_n)
            word_q[i] <= '0;
         else if (wr_en && (idx == IDX_W'(i)))
            word_q[i] <= wdata;
      end
   end

   always_comb begin
      rdata = '0;
      for (int i = 0; i < NUM_LINKS; i++)
         if (idx == IDX_W'(i)) rdata = word_q[i];
   end
endmodule

// File: rtl/icp_core.sv
module icp_core
   import icp_pkg::*;
#(
   parameter int PRIO_W     = 8,
   parameter int SRC_W      = 24,
   parameter int IPI_SRC    = 2,
   parameter int RESET_CPPR = 0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  icp_op_e                 op,
   input  logic [PRIO_W+SRC_W-1:0] wdata,
   input  logic                    src_take,
   input  logic [SRC_W-1:0]        src_id,
   input  logic [PRIO_W-1:0]       src_prio,
   output logic [PRIO_W-1:0]       cppr,
   output logic [PRIO_W-1:0]       mfrr,
   output logic [SRC_W-1:0]        xisr,
   output logic [PRIO_W-1:0]       pprio,
   output logic                    irq,
   output logic                    err,
   output logic                    rej_valid,
   output logic [SRC_W-1:0]        rej_src,
   output logic                    eoi_valid,
   output logic [SRC_W-1:0]        eoi_src
);
   localparam int              DATA_W = PRIO_W + SRC_W;
   localparam logic [SRC_W-1:0] IPI   = SRC_W'(IPI_SRC);

   logic [PRIO_W-1:0] n_cppr, n_mfrr, n_pprio;
   logic [SRC_W-1:0]  n_xisr, n_rej, n_eoi;
   logic              n_err, n_rej_v, n_eoi_v, recheck;
   logic              pend, real_pend;

   always_comb begin
      pend      = (xisr != '0);
      real_pend = pend && (xisr != IPI);
      n_cppr    = cppr;
      n_mfrr    = mfrr;
      n_xisr    = xisr;
      n_pprio   = pprio;
      n_err     = err;
      n_rej_v   = 1'b0;
      n_rej     = '0;
      n_eoi_v   = 1'b0;
      n_eoi     = '0;
      recheck   = 1'b0;
      case (op)
         OP_ACCEPT: begin
            if (pend) begin
               n_cppr  = pprio;
               n_xisr  = '0;
               n_pprio = '1;
            end
         end
         OP_CPPR_WR: begin
            n_cppr  = wdata[PRIO_W-1:0];
            recheck = 1'b1;
         end
         OP_EOI: begin
            n_cppr  = wdata[DATA_W-1 -: PRIO_W];
            recheck = 1'b1;
            if (wdata[SRC_W-1:0] != IPI) begin
               n_eoi_v = 1'b1;
               n_eoi   = wdata[SRC_W-1:0];
            end
         end
         OP_MFRR_WR: begin
            n_mfrr = wdata[PRIO_W-1:0];
            if (n_mfrr < cppr && n_mfrr < pprio) begin
               if (real_pend) begin
                  n_rej_v = 1'b1;
                  n_rej   = xisr;
               end
               n_xisr  = IPI;
               n_pprio = n_mfrr;
            end
         end
         OP_BAD_RD, OP_BAD_WR: n_err = 1'b1;
         OP_NONE: begin
            if (src_take) begin
               if (src_prio < cppr && src_prio < pprio) begin
                  if (real_pend) begin
                     n_rej_v = 1'b1;
                     n_rej   = xisr;
                  end
                  n_xisr  = src_id;
                  n_pprio = src_prio;
               end else begin
                  n_rej_v = 1'b1;
                  n_rej   = src_id;
               end
            end
         end
         default: ;
      endcase
      if (recheck && pend && (n_cppr <= pprio)) begin
         if (real_pend) begin
            n_rej_v = 1'b1;
            n_rej   = xisr;
         end
         n_xisr  = '0;
         n_pprio = '1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cppr      <= PRIO_W'(RESET_CPPR);
         mfrr      <= '1;
         xisr      <= '0;
         pprio     <= '1;
         irq       <= 1'b0;
         err       <= 1'b0;
         rej_valid <= 1'b0;
         rej_src   <= '0;
         eoi_valid <= 1'b0;
         eoi_src   <= '0;
      end else begin
         cppr      <= n_cppr;
         mfrr      <= n_mfrr;
         xisr      <= n_xisr;
         pprio     <= n_pprio;
         irq       <= (n_xisr != '0);
         err       <= n_err;
         rej_valid <= n_rej_v;
         rej_src   <= n_rej;
         eoi_valid <= n_eoi_v;
         eoi_src   <= n_eoi;
      end
   end
endmodule

// File: rtl/icp_presenter.sv
module icp_presenter
   import icp_pkg::*;
#(
   parameter int ADDR_W     = 12,
   parameter int PRIO_W     = 8,
   parameter int SRC_W      = 24,
   parameter int NUM_LINKS  = 3,
   parameter int LINK_BASE  = 16,
   parameter int IPI_SRC    = 2,
   parameter int RESET_CPPR = 0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    req_valid,
   input  logic                    req_write,
   input  logic [ADDR_W-1:0]       req_addr,
   input  logic [2:0]              req_bytes,
   input  logic [PRIO_W+SRC_W-1:0] req_wdata,
   output logic                    rsp_valid,
   output logic [PRIO_W+SRC_W-1:0] rsp_rdata,
   input  logic                    src_valid,
   input  logic [SRC_W-1:0]        src_id,
   input  logic [PRIO_W-1:0]       src_prio,
   output logic                    src_ready,
   output logic                    rej_valid,
   output logic [SRC_W-1:0]        rej_src,
   output logic                    eoi_valid,
   output logic [SRC_W-1:0]        eoi_src,
   output logic                    irq,
   output logic                    err
);
   localparam int DATA_W = PRIO_W + SRC_W;
   localparam int IDX_W  = (NUM_LINKS > 1) ? $clog2(NUM_LINKS) : 1;

   if (DATA_W != 32) begin : g_bad_word
      $error("priority plus source width must form a 32-bit word");
   end
   if (PRIO_W > 8) begin : g_bad_prio
      $error("priority must fit in one byte lane");
   end
   if ((LINK_BASE % 4) != 0 || (LINK_BASE + 4 * NUM_LINKS) > (1 << ADDR_W)) begin : g_bad_link
      $error("link words must be word aligned inside the window");
   end
   if (LINK_BASE < 16) begin : g_bad_overlap
      $error("link words overlap the priority registers");
   end

   icp_op_e           op;
   logic [IDX_W-1:0]  link_idx;
   logic [DATA_W-1:0] link_rdata;
   logic [PRIO_W-1:0] cur_cppr, cur_mfrr, cur_pprio;
   logic [SRC_W-1:0]  cur_xisr;
   logic [DATA_W-1:0] rd_mux;

   assign src_ready = !req_valid;

   icp_decode #(
      .ADDR_W(ADDR_W), .NUM_LINKS(NUM_LINKS), .LINK_BASE(LINK_BASE), .IDX_W(IDX_W)
   ) i_decode (
      .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
      .req_bytes(req_bytes), .op(op), .link_idx(link_idx)
   );

   icp_links #(
      .NUM_LINKS(NUM_LINKS), .DATA_W(DATA_W), .IDX_W(IDX_W)
   ) i_links (
      .clk(clk), .rst_n(rst_n), .wr_en(op == OP_LINK_WR), .idx(link_idx),
      .wdata(req_wdata), .rdata(link_rdata)
   );

   icp_core #(
      .PRIO_W(PRIO_W), .SRC_W(SRC_W), .IPI_SRC(IPI_SRC), .RESET_CPPR(RESET_CPPR)
   ) i_core (
      .clk(clk), .rst_n(rst_n), .op(op), .wdata(req_wdata),
      .src_take(src_valid && src_ready), .src_id(src_id), .src_prio(src_prio),
      .cppr(cur_cppr), .mfrr(cur_mfrr), .xisr(cur_xisr), .pprio(cur_pprio),
      .irq(irq), .err(err), .rej_valid(rej_valid), .rej_src(rej_src),
      .eoi_valid(eoi_valid), .eoi_src(eoi_src)
   );

   always_comb begin
      case (op)
         OP_POLL_WORD, OP_ACCEPT: rd_mux = {cur_cppr, cur_xisr};
         OP_POLL_BYTE:            rd_mux = DATA_W'(cur_cppr);
         OP_MFRR_RD:              rd_mux = DATA_W'(cur_mfrr);
         OP_LINK_RD:              rd_mux = link_rdata;
         default:                 rd_mux = '1;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= req_valid && !req_write;
         rsp_rdata <= (req_valid && !req_write) ? rd_mux : '0;
      end
   end
endmodule

// File: rtl/icp_presenter_chk.sv
module icp_presenter_chk
   import icp_pkg::*;
#(
   parameter int PRIO_W  = 8,
   parameter int SRC_W   = 24,
   parameter int IPI_SRC = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_write,
   input icp_op_e           op,
   input logic              rsp_valid,
   input logic              irq,
   input logic              err,
   input logic [PRIO_W-1:0] cppr,
   input logic [PRIO_W-1:0] pprio,
   input logic [SRC_W-1:0]  xisr,
   input logic              rej_valid,
   input logic [SRC_W-1:0]  rej_src,
   input logic              eoi_valid,
   input logic [SRC_W-1:0]  eoi_src
);
   a_r2_read_answered: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write) |=> rsp_valid);

   a_r2_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && !req_write) |=> !rsp_valid);

   a_r3_accept_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_ACCEPT) |=> !irq);

   a_r5_eoi_not_ipi: assert property (@(posedge clk) disable iff (!rst_n)
      eoi_valid |-> (eoi_src != SRC_W'(IPI_SRC)));

   a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> err);

   a_r9_reject_not_ipi: assert property (@(posedge clk) disable iff (!rst_n)
      rej_valid |-> (rej_src != SRC_W'(IPI_SRC)));

   a_r10_irq_favoured: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (xisr != '0 && pprio < cppr));
endmodule

bind icp_presenter icp_presenter_chk #(
   .PRIO_W(PRIO_W), .SRC_W(SRC_W), .IPI_SRC(IPI_SRC)
) i_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
   .op(op), .rsp_valid(rsp_valid), .irq(irq), .err(err), .cppr(cur_cppr),
   .pprio(cur_pprio), .xisr(cur_xisr), .rej_valid(rej_valid), .rej_src(rej_src),
   .eoi_valid(eoi_valid), .eoi_src(eoi_src)
);

// File: tb/test_icp_presenter.sv
module test_icp_presenter;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [11:0] req_addr = '0;
   logic [2:0]  req_bytes = '0;
   logic [31:0] req_wdata = '0;
   logic        rsp_valid;
   logic [31:0] rsp_rdata;
   logic        src_valid = 1'b0;
   logic [23:0] src_id = '0;
   logic [7:0]  src_prio = '0;
   logic        src_ready, rej_valid, eoi_valid, irq, err;
   logic [23:0] rej_src, eoi_src;

   int checks = 0;
   int errors = 0;

   // reference state
   logic [7:0]  m_cppr, m_mfrr, m_pprio;
   logic [23:0] m_xisr;
   logic        m_err;
   logic [31:0] m_link [3];
   logic        e_rsp_v, e_rej_v, e_eoi_v;
   logic [31:0] e_rsp_d;
   logic [23:0] e_rej, e_eoi;

   always #5 clk = ~clk;

   icp_presenter i_icp_presenter (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_bytes(req_bytes), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .src_valid(src_valid),
      .src_id(src_id), .src_prio(src_prio), .src_ready(src_ready),
      .rej_valid(rej_valid), .rej_src(rej_src), .eoi_valid(eoi_valid),
      .eoi_src(eoi_src), .irq(irq), .err(err)
   );

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic compare(input string tag);
      check(irq === (m_xisr != 0), "R10", "irq", 32'(irq), 32'(m_xisr != 0));
      check(rsp_valid === e_rsp_v, "R2", "rsp_valid", 32'(rsp_valid), 32'(e_rsp_v));
      if (e_rsp_v) check(rsp_rdata === e_rsp_d, tag, "rdata", rsp_rdata, e_rsp_d);
      check(rej_valid === e_rej_v, tag, "rej_valid", 32'(rej_valid), 32'(e_rej_v));
      if (e_rej_v) check(rej_src === e_rej, tag, "rej_src", 32'(rej_src), 32'(e_rej));
      check(eoi_valid === e_eoi_v, "R5", "eoi_valid", 32'(eoi_valid), 32'(e_eoi_v));
      if (e_eoi_v) check(eoi_src === e_eoi, "R5", "eoi_src", 32'(eoi_src), 32'(e_eoi));
      check(err === m_err, "R8", "err", 32'(err), 32'(m_err));
   endtask

   task automatic reject(input logic [23:0] s);
      e_rej_v = 1'b1;
      e_rej   = s;
   endtask

   task automatic drop_if_masked();
      if (m_xisr != 0 && m_cppr <= m_pprio) begin
         if (m_xisr != 24'd2) reject(m_xisr);
         m_xisr  = 0;
         m_pprio = 8'hFF;
      end
   endtask

   // one clock of stimulus; results compared at the following falling edge
   task automatic step(input bit rv, input bit rw, input logic [11:0] ad, input int nb,
                       input logic [31:0] wd, input bit sv, input logic [23:0] sid,
                       input logic [7:0] spr, input string tag);
      bit b0, w, bad;
      int wo;
      req_valid = rv; req_write = rw; req_addr = ad; req_bytes = 3'(nb);
      req_wdata = wd; src_valid = sv; src_id = sid; src_prio = spr;
      #1;
      check(src_ready === !rv, "R9", "src_ready", 32'(src_ready), 32'(!rv));
      b0 = (nb == 1) && (ad[1:0] == 2'b00);
      w  = (nb == 4);
      wo = int'(ad) / 4;
      e_rsp_v = rv && !rw; e_rsp_d = 32'hFFFF_FFFF;
      e_rej_v = 1'b0; e_rej = 0; e_eoi_v = 1'b0; e_eoi = 0;
      bad = 1'b1;
      if (rv) begin
         if (wo == 0 && !rw) begin
            if (w) begin e_rsp_d = {m_cppr, m_xisr}; bad = 0; end
            else if (b0) begin e_rsp_d = {24'd0, m_cppr}; bad = 0; end
         end else if (wo == 1) begin
            if (!rw && w) begin
               e_rsp_d = {m_cppr, m_xisr}; bad = 0;
               if (m_xisr != 0) begin m_cppr = m_pprio; m_xisr = 0; m_pprio = 8'hFF; end
            end else if (!rw && b0) begin
               e_rsp_d = {24'd0, m_cppr}; bad = 0;
            end else if (rw && b0) begin
               m_cppr = wd[7:0]; bad = 0; drop_if_masked();
            end else if (rw && w) begin
               m_cppr = wd[31:24]; bad = 0;
               if (wd[23:0] != 24'd2) begin e_eoi_v = 1'b1; e_eoi = wd[23:0]; end
               drop_if_masked();
            end
         end else if (wo == 3 && b0) begin
            bad = 0;
            if (!rw) e_rsp_d = {24'd0, m_mfrr};
            else begin
               m_mfrr = wd[7:0];
               if (m_mfrr < m_cppr && m_mfrr < m_pprio) begin
                  if (m_xisr != 0 && m_xisr != 24'd2) reject(m_xisr);
                  m_xisr = 24'd2; m_pprio = m_mfrr;
               end
            end
         end else if (wo >= 4 && wo <= 6 && w) begin
            bad = 0;
            if (rw) m_link[wo-4] = wd;
            else e_rsp_d = m_link[wo-4];
         end
         if (bad) m_err = 1'b1;
      end else if (sv) begin
         if (spr < m_cppr && spr < m_pprio) begin
            if (m_xisr != 0 && m_xisr != 24'd2) reject(m_xisr);
            m_xisr = sid; m_pprio = spr;
         end else reject(sid);
      end
      @(posedge clk);
      @(negedge clk);
      compare(tag);
   endtask

   task automatic rd(input logic [11:0] ad, input int nb, input string tag);
      step(1, 0, ad, nb, 0, 0, 0, 0, tag);
   endtask
   task automatic wr(input logic [11:0] ad, input int nb, input logic [31:0] wd, input string tag);
      step(1, 1, ad, nb, wd, 0, 0, 0, tag);
   endtask
   task automatic offer(input logic [23:0] id, input logic [7:0] pr, input string tag);
      step(0, 0, 0, 0, 0, 1, id, pr, tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      m_cppr = 0; m_mfrr = 8'hFF; m_pprio = 8'hFF; m_xisr = 0; m_err = 0;
      for (int i = 0; i < 3; i++) m_link[i] = 0;
      e_rsp_v = 0; e_rej_v = 0; e_eoi_v = 0; e_rsp_d = 0; e_rej = 0; e_eoi = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      compare("R1");
      rd(12'h000, 4, "R1");
      rd(12'h00C, 1, "R1");
      rd(12'h014, 4, "R1");
      offer(24'h000111, 8'h01, "R9");          // cppr 0: rejected
      wr(12'h004, 1, 32'h0000_00FF, "R4");
      rd(12'h000, 1, "R2");
      offer(24'h000123, 8'h05, "R9");
      rd(12'h000, 4, "R2");
      offer(24'h000456, 8'h07, "R9");          // less favoured: rejected
      offer(24'h000789, 8'h03, "R9");          // displaces 0x123
      rd(12'h004, 1, "R3");                    // byte poll, no accept
      rd(12'h004, 4, "R3");                    // accept
      rd(12'h004, 4, "R3");                    // nothing pending
      wr(12'h004, 4, 32'hFF00_0789, "R5");
      offer(24'h000ABC, 8'h10, "R9");
      wr(12'h004, 1, 32'h0000_0020, "R4");     // still masked open
      wr(12'h004, 1, 32'h0000_0010, "R4");     // equal: drop and reject
      wr(12'h004, 1, 32'h0000_00FF, "R4");
      wr(12'h00C, 1, 32'h0000_0005, "R6");     // IPI pending
      rd(12'h000, 4, "R6");
      offer(24'h000055, 8'h02, "R9");          // displaces IPI, no reject
      wr(12'h00C, 1, 32'h0000_0001, "R6");     // IPI back, reject 0x55
      rd(12'h004, 4, "R6");
      wr(12'h004, 4, 32'h0000_0002, "R5");     // IPI end: no pulse
      rd(12'h00C, 1, "R6");
      wr(12'h004, 1, 32'h0000_00FF, "R4");
      wr(12'h00C, 1, 32'h0000_00FF, "R6");     // least favoured: no IPI
      step(1, 0, 12'h000, 4, 0, 1, 24'h000777, 8'h01, "R9"); // offer during request ignored
      rd(12'h000, 4, "R9");
      wr(12'h010, 4, 32'h1111_2222, "R7");
      wr(12'h014, 4, 32'h3333_4444, "R7");
      wr(12'h018, 4, 32'h5555_6666, "R7");
      rd(12'h010, 4, "R7");
      rd(12'h014, 4, "R7");
      rd(12'h018, 4, "R7");
      rd(12'h000, 4, "R7");                    // links leave priority state alone
      // R8 illegal accesses
      rd(12'h01C, 4, "R8");
      rd(12'h000, 2, "R8");
      rd(12'h001, 1, "R8");
      rd(12'h004, 3, "R8");
      wr(12'h010, 1, 32'h0000_00AA, "R8");
      rd(12'h010, 4, "R8");
      wr(12'h000, 4, 32'h0000_0000, "R8");
      wr(12'h000, 1, 32'h0000_0000, "R8");
      rd(12'h000, 4, "R8");
      wr(12'h00C, 4, 32'h0000_0001, "R8");
      rd(12'h00C, 1, "R8");
      rd(12'h00D, 1, "R8");
      wr(12'hFFC, 4, 32'hDEAD_BEEF, "R8");
      rd(12'hFFC, 4, "R8");
      step(0, 0, 0, 0, 0, 0, 0, 0, "R8");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule